// File: doc/BRIEF.md
# Stereo Serial DAC Output Port

The block sends pairs of signed audio samples, one left and one right word of `SMP_W` bits, to an external serial DAC. It uses three wires: a bit clock, a frame clock that toggles once per sampling period, and a single data line. Each frame holds `2*SMP_W` bit clocks, which is 32 with the default of 16-bit words. The left word goes out in the first half of the frame and the right word in the second half. Three frame layouts are available: MSB first, LSB first, and a delayed layout. In the delayed layout the frame clock is inverted and the data lags the frame edge by one bit clock.

As clock master the block divides the system clock by `2*HALF_DIV` to make the bit clock, then derives the frame clock from its own slot counter. As clock slave it resynchronises the external bit and frame clocks into the system clock domain and follows them. It finds the frame boundary at the first left-going frame-clock edge it sees. A sample source supplies the words. The block raises `smp_req` during the last bit slot of a frame, and it captures `smp_left`/`smp_right` at the falling bit-clock edge that opens the next frame. Configuration inputs are static and are changed only while `rst_n` is low.

The serialiser is a four-state machine, and every move happens on an internal bit-clock edge strobe:
- HUNT (after reset, data held at 0) goes to LEFT at the first rising edge on which the frame clock has just changed to its left level.
- LEFT goes to RIGHT on the falling edge that opens slot `SMP_W`.
- RIGHT goes to REQ on the falling edge that opens the last slot.
- REQ goes to LEFT on the falling edge that opens slot 0, and the new words are captured on that edge.

Top module: `sdac_port`

## Requirements
- R1: After reset in master mode, `bclk_o` is 1, `sdata_o` is 0 and `smp_req` is 0. `fclk_o` sits at the right-channel level, which is 0 for format codes 00, 01 and 10 and 1 for code 11.
- R2: In master mode one bit-clock period lasts exactly `2*HALF_DIV` system clocks, rising edge to rising edge.
- R3: The frame clock changes only at bit-clock falling edges. It holds the left level for the first `SMP_W` slots of a frame and the right level for the remaining `SMP_W` slots. The left level is 1 for codes 00, 01 and 10 and 0 for code 11.
- R4: Format code 00 sends MSB first. Slot k (0 to 15) carries left bit 15-k, and slot 16+k carries right bit 15-k.
- R5: Format code 01 sends LSB first. Slot k carries left bit k, and slot 16+k carries right bit k.
- R6: Format code 11 delays the data by one slot. Slot k for k≥1 carries what code 00 puts in slot k-1, and slot 0 carries bit 0 of the previous frame's right word.
- R7: Format code 10 behaves exactly like code 00.
- R8: `sdata_o` changes only just after a bit-clock falling edge, so it holds one value across each rising edge and up to the next falling edge.
- R9: `smp_req` is 1 during the last slot of a frame and 0 in every other slot. The words are captured on the falling edge that opens slot 0. Changes on `smp_left`/`smp_right` after that edge do not affect the frame in progress.
- R10: With `cfg_mono`=1 the left word is sent in both halves of the frame, and `smp_right` is ignored.
- R11: With `cfg_slave`=1, `bclk_o` and `fclk_o` are held at 0. Once the frame is aligned, the data follows `bclk_i`/`fclk_i` with the same slot layout as in master mode.
- R12: Until the first frame boundary is found, `sdata_o` is 0 and `smp_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_slave | input | 1 | 0 = clock master, 1 = clock slave |
| cfg_fmt | input | 2 | Frame format: 00 MSB first, 01 LSB first, 10 as 00, 11 delayed with inverted frame clock |
| cfg_mono | input | 1 | 1 = send the left word in both halves |
| smp_left | input | SMP_W | Left sample, captured at the frame boundary |
| smp_right | input | SMP_W | Right sample, captured at the frame boundary |
| smp_req | output | 1 | High during the last slot of a frame |
| bclk_i | input | 1 | External bit clock (slave mode) |
| fclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode, else 0) |
| fclk_o | output | 1 | Generated frame clock (master mode, else 0) |
| sdata_o | output | 1 | Serial data |

## Verification
The bench builds the block with `SMP_W`=16 and `HALF_DIV`=3. An odd half-period of three system clocks puts each sampling point only a couple of clocks away from the register updates it must not see. In slave mode the bench drives its own clocks with a six-clock half-period. That is long enough for the two-stage synchroniser and the output register, so the slave path and the HUNT-to-LEFT alignment can be compared bit by bit with the master path. Sixteen-bit words give a 32-slot frame, so every slot of every format, including the wrap of the delayed layout, falls within the run.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2,
        ST_REQ   = 2'd3
    } sdac_state_e;

    localparam logic [1:0] FMT_MSB   = 2'b00;
    localparam logic [1:0] FMT_LSB   = 2'b01;
    localparam logic [1:0] FMT_RSVD  = 2'b10;
    localparam logic [1:0] FMT_DELAY = 2'b11;

    // Frame-clock level that marks the left half of a frame
    function automatic logic left_level(input logic [1:0] fmt);
        return (fmt == FMT_DELAY) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/sdac_clkgen.sv
module sdac_clkgen #(
    parameter int SMP_W    = 16,
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic left_lvl,
    output logic bclk,
    output logic fclk
);
    localparam int SLOT_W = $clog2(2 * SMP_W);
    localparam int CNT_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nx;

    assign slot_nx = slot_q + 1'b1;

    // Slot counter starts on the last slot so the first fall opens slot 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bclk   <= 1'b1;
            slot_q <= '1;
            fclk   <= ~left_lvl;
        end else if (!en) begin
            cnt_q  <= '0;
            bclk   <= 1'b1;
            slot_q <= '1;
            fclk   <= ~left_lvl;
        end else if (cnt_q == CNT_TOP) begin
            cnt_q <= '0;
            bclk  <= ~bclk;
            if (bclk) begin
                slot_q <= slot_nx;
                fclk   <= slot_nx[SLOT_W-1] ? ~left_lvl : left_lvl;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_FCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fclk) |-> $fell(bclk)); // R3

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_slave,
    input  logic left_lvl,
    input  logic bclk_int,
    input  logic fclk_int,
    input  logic bclk_ext,
    input  logic fclk_ext,
    output logic rise,
    output logic fall,
    output logic fval
);
    logic b_s1, b_s2, f_s1, f_s2;
    logic b_sel, b_d;

    // Two-stage resynchroniser for the external clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_s1 <= 1'b1;
            b_s2 <= 1'b1;
            f_s1 <= ~left_lvl;
            f_s2 <= ~left_lvl;
        end else begin
            b_s1 <= bclk_ext;
            b_s2 <= b_s1;
            f_s1 <= fclk_ext;
            f_s2 <= f_s1;
        end
    end

    assign b_sel = cfg_slave ? b_s2 : bclk_int;
    assign fval  = cfg_slave ? f_s2 : fclk_int;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_d <= 1'b1;
        else        b_d <= b_sel;
    end

    assign rise = b_sel & ~b_d;
    assign fall = ~b_sel & b_d;

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
    import sdac_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_fmt,
    input  logic             cfg_mono,
    input  logic             left_lvl,
    input  logic             rise,
    input  logic             fall,
    input  logic             fval,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    output logic             smp_req,
    output logic             sdata
);
    localparam int SLOT_W = $clog2(2 * SMP_W);
    localparam int IDX_W  = SLOT_W - 1;
    localparam logic [SLOT_W-1:0] SLOT_HALF = SLOT_W'(SMP_W);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(2 * SMP_W - 1);

    sdac_state_e state_q, state_d;

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nx;
    logic              prev_f_q;
    logic              frame_start;
    logic [SMP_W-1:0]  cur_l_q, cur_r_q;
    logic [SMP_W-1:0]  use_l, use_r, new_r;
    logic              bit_nx;
    logic              load_now;

    assign slot_nx     = slot_q + 1'b1;
    assign frame_start = rise && (fval == left_lvl) && (prev_f_q != left_lvl);
    assign new_r       = cfg_mono ? smp_left : smp_right;
    assign load_now    = fall && (state_q == ST_REQ) && (slot_nx == '0);

    function automatic logic pick_msb(input logic [SMP_W-1:0] l,
                                      input logic [SMP_W-1:0] r,
                                      input logic [SLOT_W-1:0] p);
        logic [SLOT_W-1:0] k;
        k = SLOT_LAST - p;
        return p[SLOT_W-1] ? r[k[IDX_W-1:0]] : l[k[IDX_W-1:0]];
    endfunction

    function automatic logic pick_lsb(input logic [SMP_W-1:0] l,
                                      input logic [SMP_W-1:0] r,
                                      input logic [SLOT_W-1:0] p);
        return p[SLOT_W-1] ? r[p[IDX_W-1:0]] : l[p[IDX_W-1:0]];
    endfunction

    // Slot counter advances on rising bit-clock edges, realigns on frame edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q   <= '1;
            prev_f_q <= ~left_lvl;
        end else if (rise) begin
            slot_q   <= frame_start ? '0 : slot_nx;
            prev_f_q <= fval;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (frame_start)                     state_d = ST_LEFT;
            ST_LEFT:  if (fall && slot_nx == SLOT_HALF)    state_d = ST_RIGHT;
            ST_RIGHT: if (fall && slot_nx == SLOT_LAST)    state_d = ST_REQ;
            ST_REQ:   if (fall && slot_nx == '0)           state_d = ST_LEFT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Bit for the slot that the coming falling edge opens
    always_comb begin
        use_l = (slot_nx == '0) ? smp_left : cur_l_q;
        use_r = (slot_nx == '0) ? new_r    : cur_r_q;
        unique case (cfg_fmt)
            FMT_LSB:   bit_nx = pick_lsb(use_l, use_r, slot_nx);
            FMT_DELAY: bit_nx = (slot_nx == '0) ? cur_r_q[0]
                                                : pick_msb(cur_l_q, cur_r_q, slot_nx - 1'b1);
            FMT_MSB,
            FMT_RSVD:  bit_nx = pick_msb(use_l, use_r, slot_nx);
        endcase
    end

    // Output process: data line and captured words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata   <= 1'b0;
            cur_l_q <= '0;
            cur_r_q <= '0;
        end else if (fall) begin
            sdata <= (state_q == ST_HUNT) ? 1'b0 : bit_nx;
            if (load_now) begin
                cur_l_q <= smp_left;
                cur_r_q <= new_r;
            end
        end
    end

    assign smp_req = (state_q == ST_REQ);

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $past(fall)); // R8

    AST_REQ_DROP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smp_req) |-> $past(fall)); // R9

    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |-> (!sdata && !smp_req)); // R12

endmodule

// File: rtl/sdac_port.sv
module sdac_port
    import sdac_pkg::*;
#(
    parameter int SMP_W    = 16,
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_slave,
    input  logic [1:0]       cfg_fmt,
    input  logic             cfg_mono,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    output logic             smp_req,
    input  logic             bclk_i,
    input  logic             fclk_i,
    output logic             bclk_o,
    output logic             fclk_o,
    output logic             sdata_o
);
    logic left_lvl;
    logic bclk_m, fclk_m;
    logic rise, fall, fval;

    assign left_lvl = left_level(cfg_fmt);

    sdac_clkgen #(
        .SMP_W    (SMP_W),
        .HALF_DIV (HALF_DIV)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (~cfg_slave),
        .left_lvl (left_lvl),
        .bclk     (bclk_m),
        .fclk     (fclk_m)
    );

    sdac_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_slave(cfg_slave),
        .left_lvl (left_lvl),
        .bclk_int (bclk_m),
        .fclk_int (fclk_m),
        .bclk_ext (bclk_i),
        .fclk_ext (fclk_i),
        .rise     (rise),
        .fall     (fall),
        .fval     (fval)
    );

    sdac_shift #(
        .SMP_W (SMP_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_fmt   (cfg_fmt),
        .cfg_mono  (cfg_mono),
        .left_lvl  (left_lvl),
        .rise      (rise),
        .fall      (fall),
        .fval      (fval),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .smp_req   (smp_req),
        .sdata     (sdata_o)
    );

    assign bclk_o = cfg_slave ? 1'b0 : bclk_m;
    assign fclk_o = cfg_slave ? 1'b0 : fclk_m;

endmodule

// File: tb/sdac_port_bench.sv
`timescale 1ns/1ps
module sdac_port_bench;
    localparam int W  = 16;
    localparam int HD = 3;
    localparam int SH = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_slave = 1'b0;
    logic [1:0]    cfg_fmt = 2'b00;
    logic          cfg_mono = 1'b0;
    logic [W-1:0]  smp_left, smp_right;
    logic          bclk_s, fclk_s;
    logic          smp_req, bclk_o, fclk_o, sdata_o;

    int errors = 0;
    int checks = 0;
    bit run_mon = 0;
    bit run_sclk = 0;
    bit done = 0;

    sdac_port #(.SMP_W(W), .HALF_DIV(HD)) u_sdac_port (
        .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_fmt(cfg_fmt),
        .cfg_mono(cfg_mono), .smp_left(smp_left), .smp_right(smp_right),
        .smp_req(smp_req), .bclk_i(bclk_s), .fclk_i(fclk_s),
        .bclk_o(bclk_o), .fclk_o(fclk_o), .sdata_o(sdata_o)
    );

    function automatic logic lvl(input logic [1:0] f);
        return (f == 2'b11) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic [W-1:0] pat_l(input int id);
        return W'(id * 16'h1357) ^ 16'hA5C3;
    endfunction

    function automatic logic [W-1:0] pat_r(input int id);
        return W'(id * 16'h2468) ^ 16'h5A3C;
    endfunction

    function automatic logic msb_bit(input logic [W-1:0] l, input logic [W-1:0] r, input int s);
        return (s < W) ? l[W-1-s] : r[2*W-1-s];
    endfunction

    function automatic logic exp_bit(input logic [1:0] f, input int s,
                                     input logic [W-1:0] l, input logic [W-1:0] r,
                                     input logic [W-1:0] pr);
        if (f == 2'b01) return (s < W) ? l[s] : r[s-W];
        if (f == 2'b11) return (s == 0) ? pr[0] : msb_bit(l, r, s-1);
        return msb_bit(l, r, s);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Slave-mode clock source
    int sdiv, sslot;
    always @(negedge clk) begin
        if (!run_sclk) begin
            bclk_s = 1'b1; fclk_s = ~lvl(cfg_fmt); sdiv = 0; sslot = 31;
        end else begin
            sdiv++;
            if (sdiv == SH) begin
                sdiv = 0;
                bclk_s = ~bclk_s;
                if (!bclk_s) begin
                    sslot = (sslot + 1) % 32;
                    fclk_s = (sslot < 16) ? lvl(cfg_fmt) : ~lvl(cfg_fmt);
                end
            end
        end
    end

    // Reference model: tracks slots and expected words, compares every bit
    logic obs_b, obs_f;
    assign obs_b = cfg_slave ? bclk_s : bclk_o;
    assign obs_f = cfg_slave ? fclk_s : fclk_o;

    bit locked, prev_b, pf, last_d, have_rise;
    int mslot, frame_id, cyc, last_rise;
    logic [W-1:0] cur_l, cur_r, prev_r, pend_l, pend_r;
    string dtag;

    always @(negedge clk) begin
        #1;
        cyc++;
        if (!run_mon) begin
            locked = 0; prev_b = 1; pf = ~lvl(cfg_fmt); have_rise = 0;
            mslot = 0; frame_id = 0; last_d = 0;
            cur_l = '0; cur_r = '0; prev_r = '0; pend_l = '0; pend_r = '0;
            smp_left = '0; smp_right = '0;
        end else begin
            if (!obs_b && prev_b && locked)
                check(sdata_o == last_d, "R8 data held to fall", sdata_o, last_d);
            if (obs_b && !prev_b) begin
                if (!cfg_slave && have_rise)
                    check(cyc - last_rise == 2*HD, "R2 bit period", cyc - last_rise, 2*HD);
                if (cfg_slave)
                    check(!bclk_o && !fclk_o, "R11 outputs quiet", {bclk_o, fclk_o}, 0);
                have_rise = 1; last_rise = cyc;
                if (!locked) begin
                    if (obs_f == lvl(cfg_fmt) && pf != lvl(cfg_fmt)) begin
                        locked = 1; mslot = 0;
                    end else begin
                        check(sdata_o == 0, "R12 idle data", sdata_o, 0);
                    end
                end else begin
                    mslot = (mslot + 1) % 32;
                    check(obs_f == ((mslot < 16) ? lvl(cfg_fmt) : ~lvl(cfg_fmt)),
                          "R3 frame level", obs_f, (mslot < 16) ? lvl(cfg_fmt) : ~lvl(cfg_fmt));
                end
                pf = obs_f;
                if (locked) begin
                    if (mslot == 0) begin
                        prev_r = cur_r; cur_l = pend_l; cur_r = pend_r;
                    end
                    if (cfg_slave)            dtag = "R11 slave data";
                    else if (cfg_mono)        dtag = "R10 mono data";
                    else if (cfg_fmt == 2'b00) dtag = "R4 msb data";
                    else if (cfg_fmt == 2'b01) dtag = "R5 lsb data";
                    else if (cfg_fmt == 2'b11) dtag = "R6 delayed data";
                    else                      dtag = "R7 reserved data";
                    check(sdata_o == exp_bit(cfg_fmt, mslot, cur_l, cur_r, prev_r), dtag,
                          sdata_o, exp_bit(cfg_fmt, mslot, cur_l, cur_r, prev_r));
                    check(smp_req == (mslot == 31), "R9 request slot", smp_req, mslot == 31);
                    if (mslot == 31) begin
                        frame_id++;
                        pend_l = pat_l(frame_id);
                        pend_r = cfg_mono ? pat_l(frame_id) : pat_r(frame_id);
                        smp_left = pat_l(frame_id);
                        smp_right = cfg_mono ? ~pat_r(frame_id) : pat_r(frame_id);
                    end
                    if (mslot == 4) begin
                        smp_left = ~pend_l ^ 16'h0F0F;
                        smp_right = ~pend_r ^ 16'hF00F;
                    end
                end
                last_d = sdata_o;
            end
            prev_b = obs_b;
        end
    end

    task automatic run_phase(input bit slave, input logic [1:0] fmt, input bit mono, input int frames);
        run_mon = 0; run_sclk = 0; rst_n = 0;
        cfg_slave = slave; cfg_fmt = fmt; cfg_mono = mono;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        if (!slave) begin
            check(bclk_o == 1, "R1 reset bclk", bclk_o, 1);
            check(fclk_o == ~lvl(fmt), "R1 reset fclk", fclk_o, ~lvl(fmt));
            check(sdata_o == 0 && smp_req == 0, "R1 reset data/req", {sdata_o, smp_req}, 0);
        end else begin
            repeat (40) @(negedge clk); #1;
            check(sdata_o == 0 && smp_req == 0, "R12 no clocks", {sdata_o, smp_req}, 0);
            check(bclk_o == 0 && fclk_o == 0, "R11 outputs low", {bclk_o, fclk_o}, 0);
        end
        run_mon = 1; run_sclk = slave;
        repeat (frames * 64 * (slave ? SH : HD)) @(negedge clk);
        run_mon = 0; run_sclk = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        run_phase(0, 2'b00, 0, 8);
        run_phase(0, 2'b01, 0, 8);
        run_phase(0, 2'b11, 0, 8);
        run_phase(0, 2'b10, 0, 8);
        run_phase(0, 2'b00, 1, 8);
        run_phase(1, 2'b00, 0, 8);
        run_phase(1, 2'b11, 0, 8);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end

endmodule